// File: doc/BRIEF.md
# Single-Clock FIFO with Selectable Output Timing

This block is a synchronous first-in first-out buffer on a single clock. It accepts a write request with a data word and a read request. It reports a full flag, an empty flag and a count of stored words. Two compile-time parameters fix its timing. `SHOW_AHEAD` selects how the read port behaves. When clear, a read request loads the oldest word into `q_o` one clock later. When set, the oldest word already sits on `q_o` before anyone reads it, and a read request advances to the next word. `OUT_REG` models a registered RAM output. It trades one extra clock of empty-flag delay for timing margin.

The flag, count and data latencies are exact to the cycle for each of the four combinations. A system can therefore schedule around them without handshaking. A synchronous clear empties the buffer without touching the asynchronous reset.

Top module: `scfifo_lat`

## Requirements
- R1: `full_o` is high exactly when `usedw_o` equals `DEPTH`, and it follows an accepted write or read one clock after the request edge.
- R2: `usedw_o` rises by one one clock after an accepted write alone and falls by one one clock after an accepted read alone. A write is accepted when `wr_i` is high and `full_o` is low. A read is accepted when `rd_i` is high and `empty_o` is low.
- R3: An accepted write and an accepted read in the same cycle leave `usedw_o` unchanged.
- R4: The accepted read that removes the last word sets `empty_o` one clock after its request edge, in every mode.
- R5: With `SHOW_AHEAD`=0, an accepted read puts the oldest stored word on `q_o` one clock after the request edge, in write order.
- R6: After a write into an empty FIFO, `empty_o` falls this many clocks after the write edge: 1 for normal mode without the output register, 2 for normal mode with it, 2 for show-ahead mode without it, and 3 for show-ahead mode with it.
- R7: With `SHOW_AHEAD`=1, the word written into an empty FIFO is on `q_o` by the clock on which `empty_o` falls.
- R8: With `SHOW_AHEAD`=1, an accepted read puts the next stored word on `q_o` one clock after the request edge.
- R9: A write while `full_o` is high is ignored. The count stays at `DEPTH`, and the stored words read out unchanged and in order.
- R10: A read while `empty_o` is high is ignored. The count stays unchanged, and the next written word is the next word read.
- R11: A high `sclr_i` at a clock edge empties the FIFO. One clock later `usedw_o` is 0, `full_o` is low and `empty_o` is high. Later writes follow R6.
- R12: During asynchronous reset (`rst_ni` low), `empty_o` is high, `full_o` is low and `usedw_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclr_i | input | 1 | Synchronous clear, takes priority over requests |
| wr_i | input | 1 | Write request |
| rd_i | input | 1 | Read request |
| data_i | input | DATA_W | Write data |
| q_o | output | DATA_W | Read data |
| full_o | output | 1 | FIFO holds DEPTH words |
| empty_o | output | 1 | No word may be read |
| usedw_o | output | $clog2(DEPTH)+1 | Number of stored words |

## Verification
The properties assume that `DEPTH` is a power of two and that the inputs are known at every clock edge after reset. They also assume that a request made against a flag is meant to be dropped. The count properties rely on this, because they compute the accepted operations from the same flag values the block sees.

The stimulus changes the inputs only on the falling clock edge. It shares one request stream across four instances, one per timing combination. After any write into an empty FIFO it waits at least three clocks before reading. That wait keeps every instance accepting the same reads, so all four counts stay identical.

// File: rtl/scfifo_lat_pkg.sv
package scfifo_lat_pkg;
  // extra clocks that hold empty high after the count leaves zero
  function automatic int empty_extra(input bit show_ahead, input bit out_reg);
    return int'(show_ahead) + int'(out_reg);
  endfunction
endpackage

// File: rtl/scfifo_lat_ctrl.sv
module scfifo_lat_ctrl #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int CW    = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic          empty_i,
  output logic          wr_ok_o,
  output logic          rd_ok_o,
  output logic [AW-1:0] wr_ptr_o,
  output logic [AW-1:0] rd_ptr_o,
  output logic [AW-1:0] rd_ptr_nxt_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          drained_o
);
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q, count_nxt;
  logic          full_q, drained_q;

  assign wr_ok_o = wr_i & ~full_q;
  assign rd_ok_o = rd_i & ~empty_i;

  always_comb begin
    unique case ({wr_ok_o, rd_ok_o})
      2'b10:   count_nxt = count_q + CW'(1);
      2'b01:   count_nxt = count_q - CW'(1);
      default: count_nxt = count_q;
    endcase
  end

  assign rd_ptr_nxt_o = rd_ok_o ? rd_ptr_q + AW'(1) : rd_ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q  <= '0;
      rd_ptr_q  <= '0;
      count_q   <= '0;
      full_q    <= 1'b0;
      drained_q <= 1'b1;
    end else if (sclr_i) begin
      wr_ptr_q  <= '0;
      rd_ptr_q  <= '0;
      count_q   <= '0;
      full_q    <= 1'b0;
      drained_q <= 1'b1;
    end else begin
      if (wr_ok_o) wr_ptr_q <= wr_ptr_q + AW'(1);
      rd_ptr_q  <= rd_ptr_nxt_o;
      count_q   <= count_nxt;
      full_q    <= (count_nxt == CW'(DEPTH));
      drained_q <= (count_nxt == '0);
    end
  end

  assign wr_ptr_o  = wr_ptr_q;
  assign rd_ptr_o  = rd_ptr_q;
  assign count_o   = count_q;
  assign full_o    = full_q;
  assign drained_o = drained_q;
endmodule

// File: rtl/scfifo_lat_empty.sv
module scfifo_lat_empty #(
  parameter int EXTRA = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclr_i,
  input  logic drained_i,
  output logic empty_o
);
  if (EXTRA == 0) begin : g_direct
    assign empty_o = drained_i;
  end else begin : g_delay
    logic [EXTRA-1:0] hist_q;
    // falling edge of drained is stretched, rising edge passes at once
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hist_q <= '1;
      end else if (sclr_i) begin
        hist_q <= '1;
      end else begin
        hist_q[0] <= drained_i;
        for (int i = 1; i < EXTRA; i++) hist_q[i] <= hist_q[i-1];
      end
    end
    assign empty_o = drained_i | (|hist_q);
  end
endmodule

// File: rtl/scfifo_lat_store.sv
module scfifo_lat_store #(
  parameter int DATA_W     = 8,
  parameter int DEPTH      = 16,
  parameter int AW         = 4,
  parameter bit SHOW_AHEAD = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ok_i,
  input  logic [AW-1:0]     wr_ptr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              rd_ok_i,
  input  logic [AW-1:0]     rd_ptr_i,
  input  logic [AW-1:0]     rd_ptr_nxt_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] q_q;

  always_ff @(posedge clk_i) begin
    if (wr_ok_i) mem_q[wr_ptr_i] <= data_i;
  end

  if (SHOW_AHEAD) begin : g_ahead
    logic [DATA_W-1:0] head_d;
    // bypass when the new head is written on this edge
    assign head_d = (wr_ok_i && (wr_ptr_i == rd_ptr_nxt_i)) ? data_i : mem_q[rd_ptr_nxt_i];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_q <= '0;
      else         q_q <= head_d;
    end
  end else begin : g_normal
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q_q <= '0;
      else if (rd_ok_i) q_q <= mem_q[rd_ptr_i];
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/scfifo_lat.sv
module scfifo_lat
  import scfifo_lat_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int DEPTH      = 16,
  parameter bit SHOW_AHEAD = 1'b0,
  parameter bit OUT_REG    = 1'b1,
  localparam int AW        = $clog2(DEPTH),
  localparam int CW        = AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] q_o,
  output logic              full_o,
  output logic              empty_o,
  output logic [CW-1:0]     usedw_o
);
  localparam int EXTRA = empty_extra(SHOW_AHEAD, OUT_REG);

  logic          wr_ok, rd_ok, drained, empty;
  logic [AW-1:0] wr_ptr, rd_ptr, rd_ptr_nxt;

  scfifo_lat_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
    .clk_i, .rst_ni, .sclr_i, .wr_i, .rd_i,
    .empty_i      (empty),
    .wr_ok_o      (wr_ok),
    .rd_ok_o      (rd_ok),
    .wr_ptr_o     (wr_ptr),
    .rd_ptr_o     (rd_ptr),
    .rd_ptr_nxt_o (rd_ptr_nxt),
    .count_o      (usedw_o),
    .full_o       (full_o),
    .drained_o    (drained)
  );

  scfifo_lat_empty #(.EXTRA(EXTRA)) u_empty (
    .clk_i, .rst_ni, .sclr_i,
    .drained_i (drained),
    .empty_o   (empty)
  );

  scfifo_lat_store #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW), .SHOW_AHEAD(SHOW_AHEAD)
  ) u_store (
    .clk_i, .rst_ni,
    .wr_ok_i      (wr_ok),
    .wr_ptr_i     (wr_ptr),
    .data_i       (data_i),
    .rd_ok_i      (rd_ok),
    .rd_ptr_i     (rd_ptr),
    .rd_ptr_nxt_i (rd_ptr_nxt),
    .q_o          (q_o)
  );

  assign empty_o = empty;
endmodule

// File: rtl/scfifo_lat_chk.sv
module scfifo_lat_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sclr_i,
  input logic          wr_i,
  input logic          rd_i,
  input logic          full_o,
  input logic          empty_o,
  input logic [CW-1:0] usedw_o
);
  logic wr_acc, rd_acc;
  assign wr_acc = wr_i && !full_o;
  assign rd_acc = rd_i && !empty_o;

  // R1
  full_tracks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o == (usedw_o == CW'(DEPTH)));

  // R2
  usedw_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc && !rd_acc && !sclr_i) |=> usedw_o == $past(usedw_o) + CW'(1));

  // R2
  usedw_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && !wr_acc && !sclr_i) |=> usedw_o == $past(usedw_o) - CW'(1));

  // R3
  usedw_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc && rd_acc && !sclr_i) |=> $stable(usedw_o));

  // R4
  drain_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && !wr_i && usedw_o == CW'(1) && !sclr_i) |=> empty_o);

  // R9
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && full_o && !rd_i && !sclr_i) |=> $stable(usedw_o) && full_o);

  // R10
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && empty_o && !wr_i && !sclr_i) |=> $stable(usedw_o));

  // R11
  sync_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclr_i |=> empty_o && !full_o && usedw_o == '0);
endmodule

bind scfifo_lat scfifo_lat_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sclr_i  (sclr_i),
  .wr_i    (wr_i),
  .rd_i    (rd_i),
  .full_o  (full_o),
  .empty_o (empty_o),
  .usedw_o (usedw_o)
);

// File: tb/sim_scfifo_lat.sv
module sim_scfifo_lat;
  localparam int DW = 8;
  localparam int DEPTH = 16;
  localparam int CW = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic sclr_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0;
  logic [DW-1:0] data_i = '0;

  logic [DW-1:0] q [4];
  logic          full [4];
  logic          empty [4];
  logic [CW-1:0] used [4];

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  // u0 normal+reg, u1 normal, u2 ahead+reg, u3 ahead
  scfifo_lat #(.DATA_W(DW), .DEPTH(DEPTH), .SHOW_AHEAD(1'b0), .OUT_REG(1'b1)) u0 (
    .clk_i(clk), .rst_ni, .sclr_i, .wr_i, .rd_i, .data_i,
    .q_o(q[0]), .full_o(full[0]), .empty_o(empty[0]), .usedw_o(used[0]));
  scfifo_lat #(.DATA_W(DW), .DEPTH(DEPTH), .SHOW_AHEAD(1'b0), .OUT_REG(1'b0)) u1 (
    .clk_i(clk), .rst_ni, .sclr_i, .wr_i, .rd_i, .data_i,
    .q_o(q[1]), .full_o(full[1]), .empty_o(empty[1]), .usedw_o(used[1]));
  scfifo_lat #(.DATA_W(DW), .DEPTH(DEPTH), .SHOW_AHEAD(1'b1), .OUT_REG(1'b1)) u2 (
    .clk_i(clk), .rst_ni, .sclr_i, .wr_i, .rd_i, .data_i,
    .q_o(q[2]), .full_o(full[2]), .empty_o(empty[2]), .usedw_o(used[2]));
  scfifo_lat #(.DATA_W(DW), .DEPTH(DEPTH), .SHOW_AHEAD(1'b1), .OUT_REG(1'b0)) u3 (
    .clk_i(clk), .rst_ni, .sclr_i, .wr_i, .rd_i, .data_i,
    .q_o(q[3]), .full_o(full[3]), .empty_o(empty[3]), .usedw_o(used[3]));

  // {wr, rd, expected usedw[4:0], expected full}
  localparam logic [7:0] VEC [9] = '{
    8'b1_0_00001_0, 8'b1_0_00010_0, 8'b1_0_00011_0,
    8'b1_1_00011_0, 8'b0_1_00010_0, 8'b1_1_00010_0,
    8'b0_1_00001_0, 8'b0_1_00000_0, 8'b0_0_00000_0
  };

  task automatic chk(input string tag, input int inst, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s u%0d: actual %0h expected %0h", tag, inst, act, exp);
    end
  endtask

  // call at a falling edge; returns at the next falling edge
  task automatic cyc(input logic w, input logic r, input logic [DW-1:0] d);
    wr_i = w; rd_i = r; data_i = d;
    @(posedge clk);
    @(negedge clk);
    wr_i = 1'b0; rd_i = 1'b0;
  endtask

  task automatic clear();
    sclr_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sclr_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int lat [4];
    logic [DW-1:0] qat [4];
    #3 rst_ni = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      chk("R12 empty", i, 32'(empty[i]), 32'd1);
      chk("R12 full", i, 32'(full[i]), 32'd0);
      chk("R12 usedw", i, 32'(used[i]), 32'd0);
    end
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // table: count and full across write, read and simultaneous patterns (R2, R3, R1)
    for (int v = 0; v < 9; v++) begin
      cyc(VEC[v][7], VEC[v][6], DW'(v));
      for (int i = 0; i < 4; i++) begin
        chk((VEC[v][7] && VEC[v][6]) ? "R3 usedw" : "R2 usedw", i, 32'(used[i]), 32'(VEC[v][5:1]));
        chk("R1 full", i, 32'(full[i]), 32'(VEC[v][0]));
      end
    end

    // empty deassert latency per mode (R6, R7)
    clear();
    repeat (2) @(negedge clk);
    for (int i = 0; i < 4; i++) begin lat[i] = 0; qat[i] = '0; end
    wr_i = 1'b1; data_i = 8'h5A;
    for (int k = 1; k <= 4; k++) begin
      @(posedge clk);
      @(negedge clk);
      wr_i = 1'b0;
      for (int i = 0; i < 4; i++)
        if (lat[i] == 0 && !empty[i]) begin lat[i] = k; qat[i] = q[i]; end
    end
    chk("R6 latency", 0, 32'(lat[0]), 32'd2);
    chk("R6 latency", 1, 32'(lat[1]), 32'd1);
    chk("R6 latency", 2, 32'(lat[2]), 32'd3);
    chk("R6 latency", 3, 32'(lat[3]), 32'd2);
    chk("R7 head", 2, 32'(qat[2]), 32'h5A);
    chk("R7 head", 3, 32'(qat[3]), 32'h5A);
    cyc(1'b0, 1'b1, '0);
    chk("R5 q", 0, 32'(q[0]), 32'h5A);
    chk("R5 q", 1, 32'(q[1]), 32'h5A);
    for (int i = 0; i < 4; i++) chk("R4 empty", i, 32'(empty[i]), 32'd1);

    // ordering in both read modes (R5, R7, R8, R4)
    cyc(1'b1, 1'b0, 8'hA1);
    cyc(1'b1, 1'b0, 8'hB2);
    cyc(1'b1, 1'b0, 8'hC3);
    repeat (3) @(negedge clk);
    chk("R7 head", 2, 32'(q[2]), 32'hA1);
    chk("R7 head", 3, 32'(q[3]), 32'hA1);
    cyc(1'b0, 1'b1, '0);
    chk("R5 q", 0, 32'(q[0]), 32'hA1);
    chk("R5 q", 1, 32'(q[1]), 32'hA1);
    chk("R8 next", 2, 32'(q[2]), 32'hB2);
    chk("R8 next", 3, 32'(q[3]), 32'hB2);
    cyc(1'b0, 1'b1, '0);
    chk("R5 q", 0, 32'(q[0]), 32'hB2);
    chk("R8 next", 2, 32'(q[2]), 32'hC3);
    chk("R8 next", 3, 32'(q[3]), 32'hC3);
    cyc(1'b0, 1'b1, '0);
    chk("R5 q", 1, 32'(q[1]), 32'hC3);
    for (int i = 0; i < 4; i++) chk("R4 empty", i, 32'(empty[i]), 32'd1);

    // reads while empty are dropped (R10)
    cyc(1'b0, 1'b1, '0);
    cyc(1'b0, 1'b1, '0);
    for (int i = 0; i < 4; i++) begin
      chk("R10 usedw", i, 32'(used[i]), 32'd0);
      chk("R10 empty", i, 32'(empty[i]), 32'd1);
    end
    cyc(1'b1, 1'b0, 8'hD4);
    repeat (3) @(negedge clk);
    chk("R10 head", 2, 32'(q[2]), 32'hD4);
    cyc(1'b0, 1'b1, '0);
    chk("R10 q", 0, 32'(q[0]), 32'hD4);
    chk("R10 q", 1, 32'(q[1]), 32'hD4);

    // fill, overflow attempt, drain (R1, R9)
    for (int n = 0; n < DEPTH; n++) cyc(1'b1, 1'b0, DW'(n + 16));
    for (int i = 0; i < 4; i++) chk("R1 full set", i, 32'(full[i]), 32'd1);
    cyc(1'b1, 1'b0, 8'hEE);
    for (int i = 0; i < 4; i++) begin
      chk("R9 usedw", i, 32'(used[i]), 32'(DEPTH));
      chk("R9 full", i, 32'(full[i]), 32'd1);
    end
    for (int n = 0; n < DEPTH; n++) begin
      cyc(1'b0, 1'b1, '0);
      chk("R9 order", 0, 32'(q[0]), 32'(n + 16));
      if (n == 0) chk("R1 full clear", 0, 32'(full[0]), 32'd0);
    end
    for (int i = 0; i < 4; i++) chk("R4 empty", i, 32'(empty[i]), 32'd1);

    // synchronous clear (R11)
    cyc(1'b1, 1'b0, 8'h11);
    cyc(1'b1, 1'b0, 8'h22);
    clear();
    for (int i = 0; i < 4; i++) begin
      chk("R11 usedw", i, 32'(used[i]), 32'd0);
      chk("R11 empty", i, 32'(empty[i]), 32'd1);
      chk("R11 full", i, 32'(full[i]), 32'd0);
    end
    cyc(1'b1, 1'b0, 8'h33);
    repeat (3) @(negedge clk);
    cyc(1'b0, 1'b1, '0);
    chk("R11 q", 0, 32'(q[0]), 32'h33);
    chk("R11 q", 1, 32'(q[1]), 32'h33);

    finish_run();
  end
endmodule